// File: doc/BRIEF.md
# Timekeeper Register Port with Two-Wire Serial Slave

This block is the serial front end of an eight-register timekeeping device. It watches the SCL and SDA lines, which are sampled on the system clock, and pulls SDA low through an open-drain enable when it acknowledges or sends a zero. It recognises START, repeated START and STOP. It answers one fixed 7-bit device address. A word-address pointer selects one of eight registers: seconds, minutes, century/hours, day, date, month, year and calibration, at addresses 0 to 7 in that order.

A write transaction loads the pointer and then stores bytes one after another. A read transaction returns bytes from the pointer onward. In both directions the pointer moves on at the ninth (acknowledge) clock of each data byte. The register file sits outside the block and is reached through a simple port: a combinational read of the addressed byte, and a one-cycle write strobe. While a transaction that addresses this device has the pointer on a clock register, the block raises `freeze`, which holds off the transfer of time counts into the user copy. A power-fail input ends any transfer at once and returns the pointer to zero.

Top module: `tk_i2c_port`

## Requirements
- R1: The address byte 1101000 followed by the R/W bit (D0h for write, D1h for read) is acknowledged. Any other address is left unacknowledged, and the rest of that transaction drives nothing and writes nothing until the next START.
- R2: In a write transaction, the byte after the address byte is acknowledged and loads the pointer from its low three bits.
- R3: Each later byte of a write is acknowledged and appears on `regWrData` with `regWrEn` high for exactly one cycle, with `regAddr` equal to the pointer. The pointer then advances by one at that byte's ninth clock.
- R4: The pointer wraps from 7 to 0, for reads as well as writes.
- R5: After a repeated START and D1h, the slave sends the byte at the pointer, MSB first. The pointer advances at every ninth clock, and a byte the master acknowledges is followed by the next one.
- R6: A read that is not preceded by a pointer write starts at the pointer value left by the previous transaction.
- R7: After the master does not acknowledge a read byte, the slave releases SDA and drives nothing until the next START.
- R8: `freeze` is high from the end of the address acknowledge of an addressed transaction while the pointer is 0 to 6. It is low while the pointer is 7, and low after STOP.
- R9: While `powerFail` is high, SDA is released from the next cycle, `freeze` is low and the pointer is 0. Nothing is acknowledged or written. Once `powerFail` falls, the block waits for a START.
- R10: The slave changes its SDA drive only while SCL is low, so its acknowledge holds SDA low through the whole high phase of the ninth clock.
- R11: A falling SDA while SCL is high is a START, and it restarts the address phase from any state. A rising SDA while SCL is high is a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Serial clock line, asynchronous |
| sdaIn | input | 1 | Serial data line as seen on the wire, asynchronous |
| sdaLowEn | output | 1 | Open-drain enable; 1 pulls SDA low |
| powerFail | input | 1 | Supply out of tolerance, synchronous to clk |
| regAddr | output | 3 | Register address (the pointer) |
| regWrEn | output | 1 | One-cycle register write strobe |
| regWrData | output | 8 | Byte to write |
| regRdData | input | 8 | Byte at `regAddr`, combinational from the register file |
| freeze | output | 1 | Hold off clock-to-user-copy transfers |

## Verification
The properties rely on the bus master holding each SCL phase for several system clocks, longer than the two-flop synchroniser and edge-detect delay. They also rely on SDA never changing in the same cycle as SCL, and on `powerFail` already being synchronous. The property on drive changes during SCL low is meaningful only under those conditions. The stimulus keeps within these limits: it holds every SCL half-phase for sixteen clocks and moves SDA only in the middle of the low phase. It also presents `regRdData` combinationally from a bench register array, matching the same-cycle read timing the block expects.

// File: rtl/tk_i2c_pkg.sv
package tk_i2c_pkg;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = 4;

  // bus events seen after synchronisation
  typedef struct packed {
    logic start;
    logic stop;
    logic sclRise;
    logic sclFall;
    logic sdaBit;
  } busEv_t;

  typedef enum logic [2:0] {
    SDA_HOLD,
    SDA_REL,
    SDA_ACK,
    SDA_TXLOAD,
    SDA_TXSHIFT
  } sdaCmd_t;

  // strobes from control to datapath
  typedef struct packed {
    sdaCmd_t sdaCmd;
    logic    cntClr;
    logic    ptrLoad;
    logic    ptrInc;
    logic    ptrClr;
    logic    wrStb;
  } dpCtl_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_PTR,
    ST_WR,
    ST_RD
  } phase_t;

endpackage

// File: rtl/tk_i2c_dp.sv
module tk_i2c_dp
  import tk_i2c_pkg::*;
#(
  parameter int REG_COUNT   = 8,
  parameter int SYNC_STAGES = 2,
  localparam int PTR_W      = $clog2(REG_COUNT)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sclIn,
  input  logic                sdaIn,
  input  dpCtl_t              ctl,
  input  logic [BYTE_W-1:0]   regRdData,
  output busEv_t              ev,
  output logic [CNT_W-1:0]    bitCnt,
  output logic [BYTE_W-1:0]   rxByte,
  output logic [PTR_W-1:0]    ptr,
  output logic                sdaLowEn
);

  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(REG_COUNT - 1);

  logic [SYNC_STAGES:0] sclPipe;
  logic [SYNC_STAGES:0] sdaPipe;
  logic                 sclS, sclD, sdaS, sdaD;
  logic [BYTE_W-1:0]    txShift;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-1:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-1:0], sdaIn};
    end
  end

  assign sclS = sclPipe[SYNC_STAGES-1];
  assign sclD = sclPipe[SYNC_STAGES];
  assign sdaS = sdaPipe[SYNC_STAGES-1];
  assign sdaD = sdaPipe[SYNC_STAGES];

  always_comb begin
    ev.start   = sclS && sclD && sdaD && !sdaS;
    ev.stop    = sclS && sclD && !sdaD && sdaS;
    ev.sclRise = sclS && !sclD;
    ev.sclFall = !sclS && sclD;
    ev.sdaBit  = sdaS;
  end

  // rising edges seen in the current nine-clock frame
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (ctl.cntClr) begin
      bitCnt <= '0;
    end else if (ev.sclRise && bitCnt != CNT_W'(9)) begin
      bitCnt <= bitCnt + 1'b1;
    end else if (ev.sclFall && bitCnt == CNT_W'(9)) begin
      bitCnt <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxByte <= '0;
    end else if (ev.sclRise && bitCnt < CNT_W'(8)) begin
      rxByte <= {rxByte[BYTE_W-2:0], sdaS};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (ctl.ptrClr) begin
      ptr <= '0;
    end else if (ctl.ptrLoad) begin
      ptr <= rxByte[PTR_W-1:0];
    end else if (ctl.ptrInc) begin
      ptr <= (ptr == PTR_LAST) ? '0 : ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift  <= '0;
      sdaLowEn <= 1'b0;
    end else begin
      unique case (ctl.sdaCmd)
        SDA_REL:     sdaLowEn <= 1'b0;
        SDA_ACK:     sdaLowEn <= 1'b1;
        SDA_TXLOAD: begin
          txShift  <= regRdData;
          sdaLowEn <= !regRdData[BYTE_W-1];
        end
        SDA_TXSHIFT: begin
          txShift  <= {txShift[BYTE_W-2:0], 1'b0};
          sdaLowEn <= !txShift[BYTE_W-2];
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/tk_i2c_ctrl.sv
module tk_i2c_ctrl
  import tk_i2c_pkg::*;
#(
  parameter int          REG_COUNT = 8,
  parameter logic [6:0]  DEV_ADDR  = 7'h68,
  localparam int         PTR_W     = $clog2(REG_COUNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              powerFail,
  input  busEv_t            ev,
  input  logic [CNT_W-1:0]  bitCnt,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic [PTR_W-1:0]  ptr,
  output dpCtl_t            ctl,
  output logic              freeze
);

  localparam logic [PTR_W-1:0] PTR_CAL = PTR_W'(REG_COUNT - 1);

  phase_t state, stateN;
  logic   rwBit, rwN;
  logic   masterAck, mAckN;
  logic   accessing, accN;
  logic   fall8, fall9, rise9, txStep;

  assign fall8  = ev.sclFall && bitCnt == CNT_W'(8);
  assign fall9  = ev.sclFall && bitCnt == CNT_W'(9);
  assign rise9  = ev.sclRise && bitCnt == CNT_W'(8);
  assign txStep = ev.sclFall && bitCnt >= CNT_W'(1) && bitCnt <= CNT_W'(7);

  always_comb begin
    stateN     = state;
    rwN        = rwBit;
    mAckN      = masterAck;
    accN       = accessing;
    ctl        = '0;
    ctl.sdaCmd = SDA_HOLD;
    if (powerFail) begin
      stateN     = ST_IDLE;
      accN       = 1'b0;
      ctl.ptrClr = 1'b1;
      ctl.cntClr = 1'b1;
      ctl.sdaCmd = SDA_REL;
    end else if (ev.start) begin
      stateN     = ST_DEV;
      ctl.cntClr = 1'b1;
      ctl.sdaCmd = SDA_REL;
    end else if (ev.stop) begin
      stateN     = ST_IDLE;
      accN       = 1'b0;
      ctl.cntClr = 1'b1;
      ctl.sdaCmd = SDA_REL;
    end else begin
      unique case (state)
        ST_IDLE: ;
        ST_DEV: begin
          if (fall8) begin
            if (rxByte[BYTE_W-1:1] == DEV_ADDR) begin
              ctl.sdaCmd = SDA_ACK;
              rwN        = rxByte[0];
            end else begin
              stateN = ST_IDLE;
            end
          end else if (fall9) begin
            accN = 1'b1;
            if (rwBit) begin
              stateN     = ST_RD;
              ctl.sdaCmd = SDA_TXLOAD;
            end else begin
              stateN     = ST_PTR;
              ctl.sdaCmd = SDA_REL;
            end
          end
        end
        ST_PTR: begin
          if (fall8) begin
            ctl.sdaCmd = SDA_ACK;
          end else if (rise9) begin
            ctl.ptrLoad = 1'b1;
          end else if (fall9) begin
            ctl.sdaCmd = SDA_REL;
            stateN     = ST_WR;
          end
        end
        ST_WR: begin
          if (fall8) begin
            ctl.sdaCmd = SDA_ACK;
          end else if (rise9) begin
            ctl.wrStb  = 1'b1;
            ctl.ptrInc = 1'b1;
          end else if (fall9) begin
            ctl.sdaCmd = SDA_REL;
          end
        end
        ST_RD: begin
          if (txStep) begin
            ctl.sdaCmd = SDA_TXSHIFT;
          end else if (fall8) begin
            ctl.sdaCmd = SDA_REL;
          end else if (rise9) begin
            ctl.ptrInc = 1'b1;
            mAckN      = !ev.sdaBit;
          end else if (fall9) begin
            if (masterAck) begin
              ctl.sdaCmd = SDA_TXLOAD;
            end else begin
              ctl.sdaCmd = SDA_REL;
              stateN     = ST_IDLE;
            end
          end
        end
        default: stateN = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      rwBit     <= 1'b0;
      masterAck <= 1'b0;
      accessing <= 1'b0;
    end else begin
      state     <= stateN;
      rwBit     <= rwN;
      masterAck <= mAckN;
      accessing <= accN;
    end
  end

  assign freeze = accessing && (ptr != PTR_CAL);

endmodule

// File: rtl/tk_i2c_port.sv
module tk_i2c_port
  import tk_i2c_pkg::*;
#(
  parameter int         REG_COUNT   = 8,
  parameter logic [6:0] DEV_ADDR    = 7'h68,
  parameter int         SYNC_STAGES = 2,
  localparam int        PTR_W       = $clog2(REG_COUNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaLowEn,
  input  logic              powerFail,
  output logic [PTR_W-1:0]  regAddr,
  output logic              regWrEn,
  output logic [BYTE_W-1:0] regWrData,
  input  logic [BYTE_W-1:0] regRdData,
  output logic              freeze
);

  busEv_t            busEv;
  dpCtl_t            dpCtl;
  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] rxByte;
  logic [PTR_W-1:0]  ptr;
  logic              stopEv;

  tk_i2c_dp #(
    .REG_COUNT  (REG_COUNT),
    .SYNC_STAGES(SYNC_STAGES)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .ctl      (dpCtl),
    .regRdData(regRdData),
    .ev       (busEv),
    .bitCnt   (bitCnt),
    .rxByte   (rxByte),
    .ptr      (ptr),
    .sdaLowEn (sdaLowEn)
  );

  tk_i2c_ctrl #(
    .REG_COUNT(REG_COUNT),
    .DEV_ADDR (DEV_ADDR)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .powerFail(powerFail),
    .ev       (busEv),
    .bitCnt   (bitCnt),
    .rxByte   (rxByte),
    .ptr      (ptr),
    .ctl      (dpCtl),
    .freeze   (freeze)
  );

  assign regAddr   = ptr;
  assign regWrEn   = dpCtl.wrStb;
  assign regWrData = rxByte;
  assign stopEv    = busEv.stop;

endmodule

// File: rtl/tk_i2c_chk.sv
module tk_i2c_chk #(
  parameter int  REG_COUNT = 8,
  localparam int PTR_W     = $clog2(REG_COUNT)
) (
  input logic             clk,
  input logic             rstN,
  input logic             sclIn,
  input logic             powerFail,
  input logic             sdaLowEn,
  input logic             freeze,
  input logic             regWrEn,
  input logic [PTR_W-1:0] regAddr,
  input logic             stopEv
);

  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(REG_COUNT - 1);

  // R9: power fail releases the line and drops freeze
  a_r9_pf_release: assert property (@(posedge clk) disable iff (!rstN)
    powerFail |=> !sdaLowEn);

  a_r9_pf_unfreeze: assert property (@(posedge clk) disable iff (!rstN)
    powerFail |=> (!freeze && regAddr == '0));

  // R3: a write strobe lasts one cycle and is followed by a pointer step (R4 wrap)
  a_r3_wr_pulse: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn);

  a_r3_ptr_step: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> regAddr == (($past(regAddr) == PTR_LAST) ? '0 : $past(regAddr) + 1'b1));

  // R8: STOP ends the freeze window
  a_r8_stop_unfreeze: assert property (@(posedge clk) disable iff (!rstN)
    stopEv |=> !freeze);

  // R10: the slave starts pulling SDA only while SCL is low
  a_r10_drive_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaLowEn) |-> !$past(sclIn));

endmodule

bind tk_i2c_port tk_i2c_chk #(.REG_COUNT(REG_COUNT)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .sclIn    (sclIn),
  .powerFail(powerFail),
  .sdaLowEn (sdaLowEn),
  .freeze   (freeze),
  .regWrEn  (regWrEn),
  .regAddr  (regAddr),
  .stopEv   (stopEv)
);

// File: tb/tk_i2c_port_tb_top.sv
module tk_i2c_port_tb_top;

  localparam int Q = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       mScl = 1'b1;
  logic       mSdaLow = 1'b0;
  logic       powerFail = 1'b0;
  logic       sdaIn;
  logic       sdaLowEn;
  logic [2:0] regAddr;
  logic       regWrEn;
  logic [7:0] regWrData;
  logic [7:0] regRdData;
  logic       freeze;

  logic [7:0] regs  [0:7];
  logic [7:0] model [0:7];

  typedef struct { int a; int d; } wr_t;
  wr_t expWr[$];

  int  nChk = 0;
  int  nFail = 0;
  int  r10Viol = 0;
  int  lowSeen = 0;
  bit  watchLow = 0;
  bit  done = 0;
  logic prevLow = 1'b0;

  always #4 clk = ~clk;

  assign sdaIn     = !(mSdaLow || sdaLowEn);
  assign regRdData = regs[regAddr];

  tk_i2c_port dut_i (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (mScl),
    .sdaIn    (sdaIn),
    .sdaLowEn (sdaLowEn),
    .powerFail(powerFail),
    .regAddr  (regAddr),
    .regWrEn  (regWrEn),
    .regWrData(regWrData),
    .regRdData(regRdData),
    .freeze   (freeze)
  );

  function automatic logic [7:0] initVal(input int i);
    return 8'h5A ^ 8'(i * 19);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 8; i++) regs[i] <= initVal(i);
    end else if (regWrEn) begin
      regs[regAddr] <= regWrData;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor for the write port
  always @(negedge clk) begin
    if (rstN && regWrEn) begin
      if (expWr.size() == 0) begin
        chk("R3 unexpected write strobe", 1, 0);
      end else begin
        wr_t e;
        e = expWr.pop_front();
        chk("R3 write address", int'(regAddr), e.a);
        chk("R3 write data", int'(regWrData), e.d);
      end
    end
    if (rstN && !powerFail && mScl && sdaLowEn != prevLow) r10Viol++;
    if (watchLow && sdaLowEn) lowSeen++;
    prevLow = sdaLowEn;
  end

  task automatic waitQ(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic sendStart;
    mSdaLow = 1'b0; waitQ(1);
    mScl = 1'b1;    waitQ(2);
    mSdaLow = 1'b1; waitQ(2);
    mScl = 1'b0;    waitQ(1);
  endtask

  task automatic sendStop;
    mSdaLow = 1'b1; waitQ(1);
    mScl = 1'b1;    waitQ(2);
    mSdaLow = 1'b0; waitQ(2);
  endtask

  task automatic putBit(input logic b);
    mSdaLow = !b; waitQ(1);
    mScl = 1'b1;  waitQ(2);
    mScl = 1'b0;  waitQ(1);
  endtask

  task automatic getBit(output logic b);
    logic early;
    mSdaLow = 1'b0; waitQ(1);
    mScl = 1'b1;    repeat (2) @(negedge clk);
    early = sdaIn;  waitQ(2);
    b = sdaIn;
    if (early != b) r10Viol++;
    mScl = 1'b0;    repeat (Q - 2) @(negedge clk);
    waitQ(0);
  endtask

  task automatic sendByte(input logic [7:0] v, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) putBit(v[i]);
    getBit(b);
    acked = !b;
  endtask

  task automatic recvByte(input logic ack, output logic [7:0] v);
    logic b;
    v = '0;
    for (int i = 0; i < 8; i++) begin
      getBit(b);
      v = {v[6:0], b};
    end
    putBit(!ack);
  endtask

  task automatic expectWrite(input int a, input int d);
    wr_t e;
    e.a = a; e.d = d;
    expWr.push_back(e);
    model[a] = 8'(d);
  endtask

  initial begin
    logic       ack;
    logic [7:0] v;
    logic       b;
    for (int i = 0; i < 8; i++) model[i] = initVal(i);
    repeat (6) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    chk("R10 reset sdaLowEn", int'(sdaLowEn), 0);
    chk("R8 reset freeze", int'(freeze), 0);
    chk("R3 reset regWrEn", int'(regWrEn), 0);
    chk("R9 reset pointer", int'(regAddr), 0);

    // write with wrap: pointer 5, four data bytes
    sendStart;
    sendByte(8'hD0, ack); chk("R1 write address ack", int'(ack), 1);
    sendByte(8'h05, ack); chk("R2 pointer byte ack", int'(ack), 1);
    chk("R2 pointer loaded", int'(regAddr), 5);
    chk("R8 freeze on clock register", int'(freeze), 1);
    expectWrite(5, 8'h11); sendByte(8'h11, ack); chk("R3 data ack", int'(ack), 1);
    expectWrite(6, 8'h22); sendByte(8'h22, ack); chk("R3 data ack", int'(ack), 1);
    chk("R8 freeze low at calibration", int'(freeze), 0);
    expectWrite(7, 8'h33); sendByte(8'h33, ack);
    expectWrite(0, 8'h44); sendByte(8'h44, ack);
    chk("R4 pointer wrapped", int'(regAddr), 1);
    chk("R8 freeze after wrap", int'(freeze), 1);
    sendStop;
    chk("R8 freeze after stop", int'(freeze), 0);
    chk("R3 all writes seen", expWr.size(), 0);

    // foreign address is ignored
    watchLow = 1;
    sendStart;
    sendByte(8'hA0, ack); chk("R1 foreign address no ack", int'(ack), 0);
    sendByte(8'h02, ack); chk("R1 ignored byte no ack", int'(ack), 0);
    sendByte(8'h77, ack);
    sendStop;
    watchLow = 0;
    chk("R1 no drive for foreign address", lowSeen, 0);
    chk("R1 pointer untouched", int'(regAddr), 1);
    chk("R8 no freeze for foreign address", int'(freeze), 0);

    // pointer write then repeated START read
    sendStart;
    sendByte(8'hD0, ack);
    sendByte(8'h02, ack);
    sendStart;
    sendByte(8'hD1, ack); chk("R11 repeated start read address ack", int'(ack), 1);
    recvByte(1'b1, v); chk("R5 read byte 2", int'(v), int'(model[2]));
    chk("R8 freeze during read", int'(freeze), 1);
    recvByte(1'b1, v); chk("R5 read byte 3", int'(v), int'(model[3]));
    recvByte(1'b0, v); chk("R5 read byte 4", int'(v), int'(model[4]));
    getBit(b); chk("R7 line released after nack", int'(b), 1);
    getBit(b); chk("R7 line released after nack", int'(b), 1);
    sendStop;

    // current-address read
    sendStart;
    sendByte(8'hD1, ack);
    recvByte(1'b0, v); chk("R6 read from stored pointer", int'(v), int'(model[5]));
    sendStop;

    // read across the wrap
    sendStart;
    sendByte(8'hD0, ack);
    sendByte(8'h07, ack);
    chk("R8 freeze low at pointer 7", int'(freeze), 0);
    sendStop;
    sendStart;
    sendByte(8'hD1, ack);
    recvByte(1'b1, v); chk("R4 read calibration", int'(v), int'(model[7]));
    recvByte(1'b0, v); chk("R4 read wraps to 0", int'(v), int'(model[0]));
    sendStop;

    // power fail mid byte
    sendStart;
    sendByte(8'hD0, ack);
    sendByte(8'h03, ack);
    for (int i = 0; i < 4; i++) putBit(1'b0);
    powerFail = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 sda released", int'(sdaLowEn), 0);
    chk("R9 freeze low", int'(freeze), 0);
    chk("R9 pointer reset", int'(regAddr), 0);
    watchLow = 1;
    for (int i = 0; i < 4; i++) putBit(1'b1);
    getBit(b); chk("R9 no ack during power fail", int'(b), 1);
    sendStart;
    sendByte(8'hD0, ack); chk("R9 address ignored", int'(ack), 0);
    sendByte(8'h06, ack);
    sendByte(8'h99, ack);
    sendStop;
    watchLow = 0;
    chk("R9 no drive during power fail", lowSeen, 0);
    powerFail = 1'b0;
    waitQ(2);
    sendStart;
    sendByte(8'hD1, ack);
    recvByte(1'b0, v); chk("R9 read restarts at 0", int'(v), int'(model[0]));
    sendStop;
    chk("R3 no stray writes", expWr.size(), 0);
    chk("R10 drive changes only with scl low", r10Viol, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end

endmodule